// File: doc/BRIEF.md
# Octal PSRAM Power-Up Configuration Sequencer

This block is a hardware sequencer that takes a DDR pseudo-SRAM from its power-up state to its operating configuration, with no processor involved. It issues one-byte mode-register commands to a serial-memory transaction engine through a small request port. The port carries an opcode, a register address, a direction, one write byte and a byte count. The engine answers each request with a done pulse or an error pulse.

The sequencer starts on its own after reset. It first sends a global reset in octal bootstrap mode and waits out the device's recovery time, counted in clock cycles derived from the clock frequency parameter. It then reads the identification register and checks the vendor code, and reads the remaining mode registers into shadow copies. It translates the static read-dummy and write-dummy settings into latency codes and writes back the patched registers. The last of these writes enables the 16-bit data path when hex mode is selected.

Only after the final register write does the sequencer ask the bus to leave bootstrap mode. It signals ready once that switch is acknowledged. Any failure ends in a sticky error state, from which no further requests are made.

Top module: `psram_cfg_seq`

## Requirements
- R1: While reset is held, cmd_req, mode_sw_req, ready and error are 0. The first request after reset has opcode 0xFF, address 0, cmd_write 1, cmd_len 2 and cmd_wdata 0. A request holds its fields stable until cmd_done or cmd_err.
- R2: After the reset command completes, cmd_req stays low for at least WAIT_CYC = (CLK_FREQ_HZ/1e6)*RESET_WAIT_US cycles (100 at defaults).
- R3: Register reads use opcode 0x40 with cmd_write 0. Register writes use opcode 0xC0 with cmd_write 1. Both use cmd_len 1 and the register number as cmd_addr.
- R4: The first read targets register 1. If its bits [4:0] differ from VENDOR_ID (0xD), error rises, ready never rises and no further request is made. Bits [7:5] of that register do not affect the check.
- R5: With a matching vendor code, the reads follow the order 1, 0, 2, 3, 4, 6, 8.
- R6: Register 0 is written with bits [2:0] = read dummy − 4 and bit 5 = NOT cfg_dqs_en, with all its other bits kept from the value read. A read dummy outside 4..9 raises error before any register write.
- R7: Register 4 is written with bits [2:0] = write dummy − 5, with all its other bits kept from the value read. A write dummy outside 5..10 raises error before any register write.
- R8: Writes go to register 0, then register 4. When cfg_hex_mode is 1, a third write goes to register 8 with bit 6 set and its other bits kept. When cfg_hex_mode is 0, register 8 is not written.
- R9: mode_sw_req rises only after the last register write completes. It holds without any request until mode_sw_ack. ready rises the cycle after the acknowledge and stays high.
- R10: A cmd_err pulse on any command makes error rise, and no later request or switch request is made.
- R11: ready and error are never both high, and each stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_dummy | input | DUMMY_W | Target read dummy cycles |
| cfg_wr_dummy | input | DUMMY_W | Target write dummy cycles |
| cfg_dqs_en | input | 1 | Target uses the data strobe (clears fixed latency) |
| cfg_hex_mode | input | 1 | Target bus is 16-bit data |
| cmd_req | output | 1 | Command request, held until done or error |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr | output | ADDR_W | Register address |
| cmd_write | output | 1 | 1 = write direction |
| cmd_wdata | output | 8 | Write byte |
| cmd_len | output | LEN_W | Data byte count |
| cmd_done | input | 1 | Command completed (one-cycle pulse) |
| cmd_err | input | 1 | Command failed (one-cycle pulse) |
| cmd_rdata | input | 8 | Read byte, valid with cmd_done |
| mode_sw_req | output | 1 | Request to switch bus to target mode |
| mode_sw_ack | input | 1 | Bus-mode switch acknowledged |
| ready | output | 1 | Configuration complete |
| error | output | 1 | Sequence failed |

## Verification
The bound checker watches the handshake rules on every cycle. These rules are:
- stable request fields while a request is pending;
- legal opcodes and byte counts;
- a silent port during the post-reset recovery window, counted cycle by cycle;
- a held switch request that never overlaps a command;
- sticky, mutually exclusive ready and error.

What only the bench scenarios can show is the content of the sequence. This covers the register order, the translated latency codes and the preserved shadow bits in the written values. It also covers the vendor-code decision, and that an illegal dummy setting or an engine fault at each step stops the writes.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

   typedef enum logic [3:0] {
      ST_BOOT,
      ST_RST_CMD,
      ST_RST_WAIT,
      ST_RD,
      ST_CHECK,
      ST_WR0,
      ST_WR4,
      ST_WR8,
      ST_SWITCH,
      ST_READY,
      ST_ERR
   } seq_state_t;

   localparam logic [7:0] OP_RESET    = 8'hFF;
   localparam logic [7:0] OP_MR_READ  = 8'h40;
   localparam logic [7:0] OP_MR_WRITE = 8'hC0;

   // register map positions the device decodes
   localparam int VID_LSB     = 0;
   localparam int VID_W       = 5;
   localparam int FIXLAT_BIT  = 5;
   localparam int IOMODE_BIT  = 6;
   localparam int LAT_FIELD_W = 3;

   // read step indices
   localparam int RD_STEPS  = 7;
   localparam int STEP_W    = 3;
   localparam int STEP_MR0  = 1;
   localparam int STEP_MR4  = 4;
   localparam int STEP_MR8  = 6;

   function automatic logic [3:0] step_reg(input logic [STEP_W-1:0] s);
      case (s)
         3'd0:    step_reg = 4'd1;
         3'd1:    step_reg = 4'd0;
         3'd2:    step_reg = 4'd2;
         3'd3:    step_reg = 4'd3;
         3'd4:    step_reg = 4'd4;
         3'd5:    step_reg = 4'd6;
         default: step_reg = 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/psram_cfg_wait.sv
module psram_cfg_wait #(
   parameter int CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("psram_cfg_wait: CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign expired = run && (cnt == CNT_W'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (!expired)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/psram_cfg_latenc.sv
module psram_cfg_latenc #(
   parameter int DUMMY_W = 4,
   parameter int MIN_VAL = 4,
   parameter int SPAN    = 6,
   parameter int FIELD_W = 3
) (
   input  logic [DUMMY_W-1:0] dummy,
   output logic [FIELD_W-1:0] code,
   output logic               legal
);
   localparam int MAX_VAL = MIN_VAL + SPAN - 1;

   generate
      if (SPAN > (1 << FIELD_W)) begin : g_bad_span
         $error("psram_cfg_latenc: SPAN does not fit the code field");
      end
      if (MAX_VAL >= (1 << DUMMY_W)) begin : g_bad_width
         $error("psram_cfg_latenc: DUMMY_W too narrow for the legal range");
      end
   endgenerate

   assign legal = (dummy >= DUMMY_W'(MIN_VAL)) && (dummy <= DUMMY_W'(MAX_VAL));
   assign code  = FIELD_W'(dummy - DUMMY_W'(MIN_VAL));
endmodule

// File: rtl/psram_cfg_seq.sv
module psram_cfg_seq
   import psram_cfg_pkg::*;
#(
   parameter int CLK_FREQ_HZ   = 50_000_000,
   parameter int RESET_WAIT_US = 2,
   parameter int ADDR_W        = 8,
   parameter int LEN_W         = 2,
   parameter int DUMMY_W       = 4,
   parameter int VENDOR_ID     = 13,
   parameter int RD_LAT_MIN    = 4,
   parameter int WR_LAT_MIN    = 5,
   parameter int LAT_SPAN      = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DUMMY_W-1:0] cfg_rd_dummy,
   input  logic [DUMMY_W-1:0] cfg_wr_dummy,
   input  logic               cfg_dqs_en,
   input  logic               cfg_hex_mode,
   output logic               cmd_req,
   output logic [7:0]         cmd_opcode,
   output logic [ADDR_W-1:0]  cmd_addr,
   output logic               cmd_write,
   output logic [7:0]         cmd_wdata,
   output logic [LEN_W-1:0]   cmd_len,
   input  logic               cmd_done,
   input  logic               cmd_err,
   input  logic [7:0]         cmd_rdata,
   output logic               mode_sw_req,
   input  logic               mode_sw_ack,
   output logic               ready,
   output logic               error
);
   localparam int         WAIT_CYC    = (CLK_FREQ_HZ / 1_000_000) * RESET_WAIT_US;
   localparam logic [7:0] LAT_MASK    = 8'((1 << LAT_FIELD_W) - 1);
   localparam logic [7:0] FIXLAT_MASK = 8'(1 << FIXLAT_BIT);
   localparam logic [7:0] IOMODE_MASK = 8'(1 << IOMODE_BIT);

   generate
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("psram_cfg_seq: recovery wait rounds to zero cycles");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("psram_cfg_seq: ADDR_W must reach register 8");
      end
      if (LEN_W < 2) begin : g_bad_len
         $error("psram_cfg_seq: LEN_W must hold a count of 2");
      end
      if (VENDOR_ID >= (1 << VID_W)) begin : g_bad_vid
         $error("psram_cfg_seq: VENDOR_ID wider than its field");
      end
   endgenerate

   seq_state_t          state, state_nx;
   logic [STEP_W-1:0]   rd_step;
   logic [7:0]          sh_mr0, sh_mr4, sh_mr8;
   logic                wait_done;
   logic [LAT_FIELD_W-1:0] rd_code, wr_code;
   logic                rd_legal, wr_legal;
   logic                vid_bad;
   logic [7:0]          mr0_new, mr4_new, mr8_new;

   psram_cfg_wait #(.CYCLES(WAIT_CYC)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_RST_WAIT),
      .expired (wait_done)
   );

   psram_cfg_latenc #(
      .DUMMY_W(DUMMY_W), .MIN_VAL(RD_LAT_MIN), .SPAN(LAT_SPAN), .FIELD_W(LAT_FIELD_W)
   ) u_rd_lat (
      .dummy (cfg_rd_dummy),
      .code  (rd_code),
      .legal (rd_legal)
   );

   psram_cfg_latenc #(
      .DUMMY_W(DUMMY_W), .MIN_VAL(WR_LAT_MIN), .SPAN(LAT_SPAN), .FIELD_W(LAT_FIELD_W)
   ) u_wr_lat (
      .dummy (cfg_wr_dummy),
      .code  (wr_code),
      .legal (wr_legal)
   );

   assign vid_bad = cmd_rdata[VID_LSB +: VID_W] != VID_W'(VENDOR_ID);

   assign mr0_new = (sh_mr0 & ~(LAT_MASK | FIXLAT_MASK))
                  | {{(8-LAT_FIELD_W){1'b0}}, rd_code}
                  | (cfg_dqs_en ? 8'h00 : FIXLAT_MASK);
   assign mr4_new = (sh_mr4 & ~LAT_MASK) | {{(8-LAT_FIELD_W){1'b0}}, wr_code};
   assign mr8_new = sh_mr8 | IOMODE_MASK;

   // next state
   always_comb begin
      state_nx = state;
      case (state)
         ST_BOOT:     state_nx = ST_RST_CMD;
         ST_RST_CMD:  if (cmd_err) state_nx = ST_ERR;
                      else if (cmd_done) state_nx = ST_RST_WAIT;
         ST_RST_WAIT: if (wait_done) state_nx = ST_RD;
         ST_RD: begin
            if (cmd_err)
               state_nx = ST_ERR;
            else if (cmd_done) begin
               if (rd_step == '0 && vid_bad)                   state_nx = ST_ERR;
               else if (rd_step == STEP_W'(RD_STEPS - 1))      state_nx = ST_CHECK;
            end
         end
         ST_CHECK:    state_nx = (rd_legal && wr_legal) ? ST_WR0 : ST_ERR;
         ST_WR0:      if (cmd_err) state_nx = ST_ERR;
                      else if (cmd_done) state_nx = ST_WR4;
         ST_WR4:      if (cmd_err) state_nx = ST_ERR;
                      else if (cmd_done) state_nx = cfg_hex_mode ? ST_WR8 : ST_SWITCH;
         ST_WR8:      if (cmd_err) state_nx = ST_ERR;
                      else if (cmd_done) state_nx = ST_SWITCH;
         ST_SWITCH:   if (mode_sw_ack) state_nx = ST_READY;
         default:     state_nx = state;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_BOOT;
         rd_step <= '0;
         sh_mr0  <= '0;
         sh_mr4  <= '0;
         sh_mr8  <= '0;
      end else begin
         state <= state_nx;
         if (state == ST_RD && cmd_done && !cmd_err) begin
            rd_step <= rd_step + 1'b1;
            if (rd_step == STEP_W'(STEP_MR0)) sh_mr0 <= cmd_rdata;
            if (rd_step == STEP_W'(STEP_MR4)) sh_mr4 <= cmd_rdata;
            if (rd_step == STEP_W'(STEP_MR8)) sh_mr8 <= cmd_rdata;
         end
      end
   end

   // command port
   always_comb begin
      cmd_req    = 1'b0;
      cmd_opcode = OP_MR_READ;
      cmd_addr   = '0;
      cmd_write  = 1'b0;
      cmd_wdata  = '0;
      cmd_len    = LEN_W'(1);
      case (state)
         ST_RST_CMD: begin
            cmd_req    = 1'b1;
            cmd_opcode = OP_RESET;
            cmd_write  = 1'b1;
            cmd_len    = LEN_W'(2);
         end
         ST_RD: begin
            cmd_req  = 1'b1;
            cmd_addr = ADDR_W'(step_reg(rd_step));
         end
         ST_WR0, ST_WR4, ST_WR8: begin
            cmd_req    = 1'b1;
            cmd_opcode = OP_MR_WRITE;
            cmd_write  = 1'b1;
            cmd_addr   = (state == ST_WR0) ? ADDR_W'(0) :
                         (state == ST_WR4) ? ADDR_W'(4) : ADDR_W'(8);
            cmd_wdata  = (state == ST_WR0) ? mr0_new :
                         (state == ST_WR4) ? mr4_new : mr8_new;
         end
         default: ;
      endcase
   end

   assign mode_sw_req = (state == ST_SWITCH);
   assign ready       = (state == ST_READY);
   assign error       = (state == ST_ERR);

endmodule

// File: rtl/psram_cfg_seq_chk.sv
module psram_cfg_seq_chk #(
   parameter int CLK_FREQ_HZ   = 50_000_000,
   parameter int RESET_WAIT_US = 2,
   parameter int ADDR_W        = 8,
   parameter int LEN_W         = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_req,
   input logic [7:0]        cmd_opcode,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              cmd_write,
   input logic [LEN_W-1:0]  cmd_len,
   input logic              cmd_done,
   input logic              cmd_err,
   input logic              mode_sw_req,
   input logic              mode_sw_ack,
   input logic              ready,
   input logic              error
);
   localparam int WAIT_CYC = (CLK_FREQ_HZ / 1_000_000) * RESET_WAIT_US;

   logic armed;
   int   quiet_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         quiet_cnt <= 0;
      end else if (cmd_req && cmd_done && cmd_opcode == 8'hFF) begin
         armed     <= 1'b1;
         quiet_cnt <= 0;
      end else if (armed && quiet_cnt < WAIT_CYC) begin
         quiet_cnt <= quiet_cnt + 1;
      end
   end

   a_r1_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req && !cmd_done && !cmd_err |=> cmd_req && $stable(cmd_opcode) && $stable(cmd_addr) && $stable(cmd_write));

   a_r2_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
      armed && quiet_cnt < WAIT_CYC |-> !cmd_req);

   a_r3_opcode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> (cmd_opcode == 8'hFF || cmd_opcode == 8'h40 || cmd_opcode == 8'hC0));

   a_r3_dir_len: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req && cmd_opcode != 8'hFF |-> cmd_len == LEN_W'(1) && cmd_write == (cmd_opcode == 8'hC0));

   a_r9_switch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sw_req && !mode_sw_ack |=> mode_sw_req);

   a_r9_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sw_req |-> !cmd_req);

   a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !cmd_req && !mode_sw_req);

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> error);

   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && error));

endmodule

bind psram_cfg_seq psram_cfg_seq_chk #(
   .CLK_FREQ_HZ   (CLK_FREQ_HZ),
   .RESET_WAIT_US (RESET_WAIT_US),
   .ADDR_W        (ADDR_W),
   .LEN_W         (LEN_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_req     (cmd_req),
   .cmd_opcode  (cmd_opcode),
   .cmd_addr    (cmd_addr),
   .cmd_write   (cmd_write),
   .cmd_len     (cmd_len),
   .cmd_done    (cmd_done),
   .cmd_err     (cmd_err),
   .mode_sw_req (mode_sw_req),
   .mode_sw_ack (mode_sw_ack),
   .ready       (ready),
   .error       (error)
);

// File: tb/psram_cfg_seq_test.sv
module psram_cfg_seq_test;
   localparam int W = (50_000_000 / 1_000_000) * 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cfg_rd_dummy = 4'd6, cfg_wr_dummy = 4'd6;
   logic       cfg_dqs_en = 1'b0, cfg_hex_mode = 1'b0;
   logic       cmd_req, cmd_write;
   logic [7:0] cmd_opcode, cmd_wdata, cmd_rdata;
   logic [7:0] cmd_addr;
   logic [1:0] cmd_len;
   logic       cmd_done, cmd_err;
   logic       mode_sw_req, mode_sw_ack, ready, error;

   always #10 clk = ~clk;

   psram_cfg_seq uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_rd_dummy(cfg_rd_dummy), .cfg_wr_dummy(cfg_wr_dummy),
      .cfg_dqs_en(cfg_dqs_en), .cfg_hex_mode(cfg_hex_mode),
      .cmd_req(cmd_req), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
      .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
      .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_rdata(cmd_rdata),
      .mode_sw_req(mode_sw_req), .mode_sw_ack(mode_sw_ack),
      .ready(ready), .error(error)
   );

   int checks = 0, failures = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [7:0] mr [0:15];
   logic [7:0] lg_op [0:31], lg_addr [0:31], lg_data [0:31];
   logic       lg_wr [0:31];
   int         lg_len [0:31];
   int         log_n = 0;
   int         eng_err_at = -1, eng_lat = 2;
   bit         rst_done_seen = 0, after_seen = 0;
   int         rst_done_cyc = 0, after_cyc = 0;
   bit         sw_seen = 0;
   int         sw_cmds = 0;

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // transaction engine and mode-register model
   initial begin
      cmd_done = 1'b0; cmd_err = 1'b0; cmd_rdata = 8'h00;
      forever begin
         @(negedge clk);
         if (rst_n && cmd_req) begin
            int idx;
            idx = log_n;
            if (idx < 32) begin
               lg_op[idx] = cmd_opcode; lg_addr[idx] = cmd_addr;
               lg_data[idx] = cmd_wdata; lg_wr[idx] = cmd_write;
               lg_len[idx] = int'(cmd_len);
            end
            log_n++;
            if (rst_done_seen && !after_seen) begin
               after_seen = 1; after_cyc = cyc;
            end
            repeat (eng_lat) @(negedge clk);
            if (idx == eng_err_at) cmd_err = 1'b1;
            else begin
               if (!cmd_write) cmd_rdata = mr[cmd_addr[3:0]];
               else if (cmd_opcode == 8'hC0) mr[cmd_addr[3:0]] = cmd_wdata;
               if (cmd_opcode == 8'hFF) begin
                  rst_done_seen = 1; rst_done_cyc = cyc;
               end
               cmd_done = 1'b1;
            end
            @(negedge clk);
            cmd_done = 1'b0; cmd_err = 1'b0;
         end
      end
   end

   // bus-mode switch model
   initial begin
      mode_sw_ack = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n && mode_sw_req && !mode_sw_ack) begin
            if (!sw_seen) begin sw_seen = 1; sw_cmds = log_n; end
            repeat (2) @(negedge clk);
            mode_sw_ack = 1'b1;
            @(negedge clk);
            mode_sw_ack = 1'b0;
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      report();
   end

   task automatic run(input int rd, input int wr, input bit dqs, input bit hex,
                      input logic [7:0] mr1v, input int err_at, input int tag);
      logic [7:0] init [0:15];
      logic [7:0] e_op [0:15], e_addr [0:15], e_data [0:15];
      logic [7:0] x0, x4, x8, emr0, emr4, emr8;
      int en, full, rdl [7];
      bit vid_ok, rd_ok, wr_ok, cfg_ok, ok;
      string otag;
      rdl = '{1, 0, 2, 3, 4, 6, 8};
      for (int k = 0; k < 16; k++) init[k] = 8'(8'hA5 ^ (k * 8'h1B) ^ tag);
      init[1] = mr1v;
      for (int k = 0; k < 16; k++) mr[k] = init[k];
      rst_n = 1'b0;
      cfg_rd_dummy = 4'(rd); cfg_wr_dummy = 4'(wr);
      cfg_dqs_en = dqs; cfg_hex_mode = hex;
      eng_err_at = err_at; eng_lat = 1 + (tag % 3);
      repeat (3) @(negedge clk);
      log_n = 0; rst_done_seen = 0; after_seen = 0; sw_seen = 0; sw_cmds = 0;
      // R1: quiet outputs while reset is held
      chk(!cmd_req && !ready && !error && !mode_sw_req, "R1", "outputs in reset",
          {cmd_req, ready, error, mode_sw_req}, 0);
      rst_n = 1'b1;
      for (int t = 0; t < 3000 && !(ready || error); t++) @(negedge clk);
      repeat (12) @(negedge clk);

      // expected sequence
      vid_ok = (mr1v[4:0] == 5'hD);
      rd_ok  = (rd >= 4 && rd <= 9);
      wr_ok  = (wr >= 5 && wr <= 10);
      cfg_ok = vid_ok && rd_ok && wr_ok;
      x0 = (init[0] & 8'hD8) | 8'((rd - 4) & 7) | (dqs ? 8'h00 : 8'h20);
      x4 = (init[4] & 8'hF8) | 8'((wr - 5) & 7);
      x8 = init[8] | 8'h40;
      en = 0;
      e_op[en] = 8'hFF; e_addr[en] = 0; e_data[en] = 0; en++;
      for (int k = 0; k < (vid_ok ? 7 : 1); k++) begin
         e_op[en] = 8'h40; e_addr[en] = 8'(rdl[k]); e_data[en] = 0; en++;
      end
      if (cfg_ok) begin
         e_op[en] = 8'hC0; e_addr[en] = 0; e_data[en] = x0; en++;
         e_op[en] = 8'hC0; e_addr[en] = 4; e_data[en] = x4; en++;
         if (hex) begin e_op[en] = 8'hC0; e_addr[en] = 8; e_data[en] = x8; en++; end
      end
      full = en;
      if (err_at >= 0 && err_at < full) en = err_at + 1;
      ok = cfg_ok && !(err_at >= 0 && err_at < full);
      emr0 = init[0]; emr4 = init[4]; emr8 = init[8];
      for (int i = 0; i < en; i++) begin
         if (e_op[i] == 8'hC0 && i != err_at) begin
            if (e_addr[i] == 0) emr0 = e_data[i];
            if (e_addr[i] == 4) emr4 = e_data[i];
            if (e_addr[i] == 8) emr8 = e_data[i];
         end
      end
      otag = (err_at >= 0 && err_at < full) ? "R10" : !vid_ok ? "R4" :
             !rd_ok ? "R6" : !wr_ok ? "R7" : "R9";

      // R1: reset command fields
      chk(log_n > 0 && lg_op[0] == 8'hFF && lg_addr[0] == 0 && lg_wr[0] && lg_len[0] == 2 && lg_data[0] == 0,
          "R1", "reset command", log_n > 0 ? int'(lg_op[0]) : -1, 255);
      // R2: recovery gap
      if (en > 1)
         chk(after_seen && (after_cyc - rst_done_cyc) >= W + 1, "R2", "recovery gap",
             after_cyc - rst_done_cyc, W + 1);
      // R8/R4/R10: command count, nothing extra afterwards
      chk(log_n == en, otag, "command count", log_n, en);
      for (int i = 1; i < en && i < log_n; i++) begin
         if (e_op[i] == 8'h40) begin
            // R3, R5: read opcode, direction, length, register order
            chk(lg_op[i] == 8'h40 && !lg_wr[i] && lg_len[i] == 1 && lg_addr[i] == e_addr[i],
                "R5", "read step register", int'(lg_addr[i]), int'(e_addr[i]));
         end else begin
            // R3 opcode and length, R6/R7/R8 data
            chk(lg_op[i] == 8'hC0 && lg_wr[i] && lg_len[i] == 1 && lg_addr[i] == e_addr[i],
                "R8", "write step register", int'(lg_addr[i]), int'(e_addr[i]));
            chk(lg_data[i] == e_data[i], e_addr[i] == 0 ? "R6" : e_addr[i] == 4 ? "R7" : "R8",
                "write byte", int'(lg_data[i]), int'(e_data[i]));
         end
      end
      chk(ready == ok && error == !ok, otag, "final ready/error", {ready, error}, {ok, !ok});
      chk(!(ready && error), "R11", "ready and error exclusive", {ready, error}, 0);
      chk(mr[0] == emr0, "R6", "register 0 final", mr[0], emr0);
      chk(mr[4] == emr4, "R7", "register 4 final", mr[4], emr4);
      chk(mr[8] == emr8, "R8", "register 8 final", mr[8], emr8);
      if (ok) chk(sw_seen && sw_cmds == en, "R9", "switch after last write", sw_cmds, en);
      else    chk(!sw_seen, "R10", "no switch request on failure", sw_seen, 0);
   endtask

   initial begin
      int tag;
      tag = 0;
      // sweep all dummy settings around both legal ranges
      for (int rd = 3; rd <= 10; rd++)
         for (int wr = 4; wr <= 11; wr++) begin
            run(rd, wr, rd[0], wr[0], 8'h0D, -1, tag);
            tag++;
         end
      run(0, 15, 1'b1, 1'b1, 8'h0D, -1, tag++);           // R6 far out of range
      run(15, 0, 1'b0, 1'b0, 8'h0D, -1, tag++);           // R6/R7
      // R4: vendor code
      run(6, 7, 1'b0, 1'b1, 8'h0C, -1, tag++);
      run(6, 7, 1'b0, 1'b1, 8'h1D, -1, tag++);
      run(6, 7, 1'b1, 1'b1, 8'hED, -1, tag++);            // upper bits ignored
      // R10: engine fault at every step of a hex sequence
      for (int e = 0; e < 11; e++) run(9, 10, 1'b1, 1'b1, 8'h8D, e, tag++);
      report();
   end
endmodule